// File: doc/BRIEF.md
# Lead-Acid Charge Stage Sequencer

This block picks the charging stage of a 12 V lead-acid battery. It receives fixed-point battery voltage and charge current samples, each marked by a one-cycle valid strobe. The thresholds arrive as constant inputs. From these it decides which stage the charger is in. For each stage it reports whether maximum-power-point tracking should run and whether the voltage loop or input regulation is in charge. It also presents the reference that the downstream compensator should follow: a current in the two current-driven stages, or a voltage in the two voltage-driven stages. The compensators, the tracking algorithm and the converter are outside the block.

The machine has four states, each with one named exit:

- TRICKLE, code 0. A deeply discharged battery is fed a small fixed current.
  - Exit ENABLE_BULK leads to BULK.
- BULK, code 1. A constant current is requested and tracking runs.
  - Exit REACH_KNEE leads to OVERCHARGE.
- OVERCHARGE, code 2. The voltage loop holds the overcharge voltage and tracking stops.
  - Exit TAPER_DONE leads to FLOAT.
- FLOAT, code 3. The float voltage is held against self-discharge.
  - Exit SAG_RECHARGE leads back to BULK.

An exit is taken only after its condition has held on a number of consecutive valid samples. If a battery never climbs out of TRICKLE, a timer raises a shorted-cell fault.

Ratio thresholds use exact integer arithmetic. The "0.95 of overcharge voltage" test is written as 20·v > 19·v_over. The "90% of float voltage" test is written as 10·v < 9·v_float.

Top module: `chg_stage_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, the outputs are:
  - stage = 0 (TRICKLE)
  - mppt_en = 0
  - vloop_sel = 0
  - ref_val = i_trickle
  - fault_short = 0
- R2: The stage code is 0 TRICKLE, 1 BULK, 2 OVERCHARGE, 3 FLOAT.
  - mppt_en is 1 only in BULK.
  - vloop_sel is 1 in OVERCHARGE and FLOAT, and 0 otherwise.
  - ref_val is i_trickle, i_bulk, v_over or v_float, in stage-code order.
- R3: ENABLE_BULK: TRICKLE moves to BULK on the clock edge of the QUAL_M-th consecutive valid sample with v_batt > v_dischg. A voltage equal to or below v_dischg keeps TRICKLE.
- R4: REACH_KNEE: BULK moves to OVERCHARGE on the QUAL_M-th consecutive valid sample with 20·v_batt > 19·v_over.
- R5: TAPER_DONE: OVERCHARGE moves to FLOAT on the TAPER_N-th consecutive valid sample with i_chg < i_taper.
- R6: SAG_RECHARGE: FLOAT moves to BULK on the QUAL_M-th consecutive valid sample with 10·v_batt < 9·v_float.
- R7: Consecutive-sample counting follows these rules:
  - A valid sample that fails the current state's exit condition restarts the count.
  - Cycles without smp_valid neither count nor restart.
  - The stage changes only on an edge where smp_valid is 1.
- R8: The shorted-cell fault works as follows:
  - fault_short rises on the clock edge of the first valid sample in TRICKLE that brings the number of TRICKLE samples above trickle_limit.
  - It stays high while the stage is TRICKLE.
  - It reads 0 in every other stage.
- R9: Only the four named transitions exist. The exit conditions of other states have no effect on the current stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | One-cycle strobe marking a new sample pair |
| v_batt | input | VW | Battery voltage sample |
| i_chg | input | VW | Charge current sample |
| v_dischg | input | VW | Deep-discharge voltage threshold |
| v_over | input | VW | Overcharge voltage (reference and knee base) |
| v_float | input | VW | Float voltage (reference and sag base) |
| i_trickle | input | VW | Trickle current reference |
| i_bulk | input | VW | Bulk current reference |
| i_taper | input | VW | Taper current threshold ending overcharge |
| trickle_limit | input | TW | Allowed number of TRICKLE samples before fault |
| stage | output | 2 | Current stage code |
| mppt_en | output | 1 | Tracking enable |
| vloop_sel | output | 1 | 1 = voltage loop, 0 = current/input regulation |
| ref_val | output | VW | Reference for the active loop |
| fault_short | output | 1 | Shorted-cell fault flag |

## Verification
The bench builds the block with QUAL_M = 3, TAPER_N = 5 and TW = 8, and drives trickle_limit = 6. These small counts let every sweep reach its qualification point within a handful of samples. The bench sweeps the voltage in single-LSB steps around each of the three voltage knees, and sweeps the current in single-LSB steps around the taper threshold. Each sweep checks the exact count at which the stage moves, and also checks that one sample fewer does not move it. The short limit lets the bench observe the fault appear on exactly the seventh trickle sample and clear on the exit to BULK. The bench also checks that the deliberately differing lengths QUAL_M and TAPER_N are each applied to the right state.

// File: rtl/chg_stage_pkg.sv
package chg_stage_pkg;
    typedef enum logic [1:0] {
        STG_TRICKLE = 2'd0,
        STG_BULK    = 2'd1,
        STG_OVER    = 2'd2,
        STG_FLOAT   = 2'd3
    } stage_t;
endpackage

// File: rtl/chg_stage_thresh.sv
// Exact integer comparators for the four exit conditions.
module chg_stage_thresh #(
    parameter int VW = 12
) (
    input  logic [VW-1:0] v_batt,
    input  logic [VW-1:0] i_chg,
    input  logic [VW-1:0] v_dischg,
    input  logic [VW-1:0] v_over,
    input  logic [VW-1:0] v_float,
    input  logic [VW-1:0] i_taper,
    output logic          above_dischg,
    output logic          above_knee_hi,
    output logic          below_knee_lo,
    output logic          below_taper
);
    localparam int PW = VW + 5;

    logic [PW-1:0] v_x20, over_x19, v_x10, float_x9;

    assign v_x20    = PW'(v_batt)  * PW'(20);
    assign over_x19 = PW'(v_over)  * PW'(19);
    assign v_x10    = PW'(v_batt)  * PW'(10);
    assign float_x9 = PW'(v_float) * PW'(9);

    assign above_dischg  = v_batt > v_dischg;
    assign above_knee_hi = v_x20 > over_x19;
    assign below_knee_lo = v_x10 < float_x9;
    assign below_taper   = i_chg < i_taper;
endmodule

// File: rtl/chg_stage_qualify.sv
// Counts consecutive valid samples meeting the active exit condition.
module chg_stage_qualify #(
    parameter int QW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_valid,
    input  logic          cond,
    input  logic [QW-1:0] target,
    output logic          fire
);
    logic [QW-1:0] run_q;

    assign fire = smp_valid && cond && (run_q == target - QW'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (smp_valid) begin
            if (!cond || fire) begin
                run_q <= '0;
            end else begin
                run_q <= run_q + QW'(1);
            end
        end
    end
endmodule

// File: rtl/chg_trickle_timer.sv
// Saturating sample counter for time spent in trickle charge.
module chg_trickle_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_trickle,
    input  logic          smp_valid,
    input  logic [TW-1:0] limit,
    output logic          fault
);
    logic [TW-1:0] age_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (!in_trickle) begin
            age_q <= '0;
        end else if (smp_valid && (age_q != '1)) begin
            age_q <= age_q + TW'(1);
        end
    end

    assign fault = in_trickle && (age_q > limit);
endmodule

// File: rtl/chg_stage_ctrl.sv
module chg_stage_ctrl
    import chg_stage_pkg::*;
#(
    parameter int VW      = 12,
    parameter int QUAL_M  = 4,
    parameter int TAPER_N = 8,
    parameter int TW      = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_valid,
    input  logic [VW-1:0] v_batt,
    input  logic [VW-1:0] i_chg,
    input  logic [VW-1:0] v_dischg,
    input  logic [VW-1:0] v_over,
    input  logic [VW-1:0] v_float,
    input  logic [VW-1:0] i_trickle,
    input  logic [VW-1:0] i_bulk,
    input  logic [VW-1:0] i_taper,
    input  logic [TW-1:0] trickle_limit,
    output logic [1:0]    stage,
    output logic          mppt_en,
    output logic          vloop_sel,
    output logic [VW-1:0] ref_val,
    output logic          fault_short
);
    localparam int QMAX = (QUAL_M > TAPER_N) ? QUAL_M : TAPER_N;
    localparam int QW   = $clog2(QMAX + 1);

    stage_t        state_q, state_d;
    logic          above_dischg, above_knee_hi, below_knee_lo, below_taper;
    logic          exit_cond, exit_fire;
    logic [QW-1:0] exit_len;

    chg_stage_thresh #(.VW(VW)) u_thresh (
        .v_batt        (v_batt),
        .i_chg         (i_chg),
        .v_dischg      (v_dischg),
        .v_over        (v_over),
        .v_float       (v_float),
        .i_taper       (i_taper),
        .above_dischg  (above_dischg),
        .above_knee_hi (above_knee_hi),
        .below_knee_lo (below_knee_lo),
        .below_taper   (below_taper)
    );

    // Exit condition and required run length for the current state.
    always_comb begin
        exit_cond = 1'b0;
        exit_len  = QW'(QUAL_M);
        unique case (state_q)
            STG_TRICKLE: exit_cond = above_dischg;
            STG_BULK:    exit_cond = above_knee_hi;
            STG_OVER: begin
                exit_cond = below_taper;
                exit_len  = QW'(TAPER_N);
            end
            STG_FLOAT:   exit_cond = below_knee_lo;
        endcase
    end

    chg_stage_qualify #(.QW(QW)) u_qualify (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .cond      (exit_cond),
        .target    (exit_len),
        .fire      (exit_fire)
    );

    chg_trickle_timer #(.TW(TW)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_trickle (state_q == STG_TRICKLE),
        .smp_valid  (smp_valid),
        .limit      (trickle_limit),
        .fault      (fault_short)
    );

    // Next-state selection: ENABLE_BULK, REACH_KNEE, TAPER_DONE, SAG_RECHARGE.
    always_comb begin
        state_d = state_q;
        if (exit_fire) begin
            unique case (state_q)
                STG_TRICKLE: state_d = STG_BULK;
                STG_BULK:    state_d = STG_OVER;
                STG_OVER:    state_d = STG_FLOAT;
                STG_FLOAT:   state_d = STG_BULK;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= STG_TRICKLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Per-stage outputs.
    always_comb begin
        mppt_en   = 1'b0;
        vloop_sel = 1'b0;
        ref_val   = i_trickle;
        unique case (state_q)
            STG_TRICKLE: ref_val = i_trickle;
            STG_BULK: begin
                mppt_en = 1'b1;
                ref_val = i_bulk;
            end
            STG_OVER: begin
                vloop_sel = 1'b1;
                ref_val   = v_over;
            end
            STG_FLOAT: begin
                vloop_sel = 1'b1;
                ref_val   = v_float;
            end
        endcase
    end

    assign stage = state_q;
endmodule

// File: rtl/chg_stage_ctrl_chk.sv
module chg_stage_ctrl_chk #(
    parameter int VW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          smp_valid,
    input logic [VW-1:0] v_batt,
    input logic [VW-1:0] v_dischg,
    input logic [VW-1:0] v_float,
    input logic [1:0]    stage,
    input logic          mppt_en,
    input logic          fault_short
);
    AST_STEP_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        (stage != $past(stage)) |-> $past(smp_valid)); // R7

    AST_LEGAL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (stage != $past(stage)) |->
            (($past(stage) == 2'd0 && stage == 2'd1) ||
             ($past(stage) == 2'd1 && stage == 2'd2) ||
             ($past(stage) == 2'd2 && stage == 2'd3) ||
             ($past(stage) == 2'd3 && stage == 2'd1))); // R9

    AST_TRICKLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (stage == 2'd0 && !(v_batt > v_dischg)) |=> (stage == 2'd0)); // R3

    AST_FLOAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (stage == 2'd3 && (32'(v_batt) * 32'd10 >= 32'(v_float) * 32'd9))
            |=> (stage == 2'd3)); // R6

    AST_FAULT_IN_TRICKLE: assert property (@(posedge clk) disable iff (!rst_n)
        fault_short |-> (stage == 2'd0)); // R8

    AST_MPPT_NOT_VOLT: assert property (@(posedge clk) disable iff (!rst_n)
        mppt_en |-> (stage == 2'd1)); // R2
endmodule

bind chg_stage_ctrl chg_stage_ctrl_chk #(.VW(VW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .smp_valid   (smp_valid),
    .v_batt      (v_batt),
    .v_dischg    (v_dischg),
    .v_float     (v_float),
    .stage       (stage),
    .mppt_en     (mppt_en),
    .fault_short (fault_short)
);

// File: tb/chg_stage_ctrl_bench.sv
module chg_stage_ctrl_bench;
    localparam int VW = 12;
    localparam int M  = 3;
    localparam int N  = 5;
    localparam int TW = 8;

    localparam int VDIS = 1050;
    localparam int VOVR = 1500;
    localparam int VFLT = 1350;
    localparam int ITRK = 20;
    localparam int IBLK = 300;
    localparam int ITAP = 50;
    localparam int LIM  = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          smp_valid = 1'b0;
    logic [VW-1:0] v_batt = '0;
    logic [VW-1:0] i_chg = '0;
    logic [1:0]    stage;
    logic          mppt_en, vloop_sel, fault_short;
    logic [VW-1:0] ref_val;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    chg_stage_ctrl #(.VW(VW), .QUAL_M(M), .TAPER_N(N), .TW(TW)) u_chg_stage_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .smp_valid     (smp_valid),
        .v_batt        (v_batt),
        .i_chg         (i_chg),
        .v_dischg      (VW'(VDIS)),
        .v_over        (VW'(VOVR)),
        .v_float       (VW'(VFLT)),
        .i_trickle     (VW'(ITRK)),
        .i_bulk        (VW'(IBLK)),
        .i_taper       (VW'(ITAP)),
        .trickle_limit (TW'(LIM)),
        .stage         (stage),
        .mppt_en       (mppt_en),
        .vloop_sel     (vloop_sel),
        .ref_val       (ref_val),
        .fault_short   (fault_short)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        smp_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send(input int v, input int i);
        @(negedge clk);
        v_batt = VW'(v);
        i_chg = VW'(i);
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic send_n(input int cnt, input int v, input int i);
        for (int k = 0; k < cnt; k++) send(v, i);
    endtask

    task automatic check_outputs(input string tag, input int st);
        int exp_ref;
        exp_ref = (st == 0) ? ITRK : (st == 1) ? IBLK : (st == 2) ? VOVR : VFLT;
        check({tag, " stage"}, int'(stage), st);
        check({tag, " mppt_en"}, int'(mppt_en), (st == 1) ? 1 : 0);
        check({tag, " vloop_sel"}, int'(vloop_sel), (st >= 2) ? 1 : 0);
        check({tag, " ref_val"}, int'(ref_val), exp_ref);
    endtask

    task automatic go_bulk();
        do_reset();
        send_n(M, 1200, 100);
    endtask

    task automatic go_over();
        go_bulk();
        send_n(M, 1430, 100);
    endtask

    task automatic go_float();
        go_over();
        send_n(N, 1430, 10);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_outputs("R1 in reset", 0);
        check("R1 fault in reset", int'(fault_short), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_outputs("R1 after reset", 0);

        // R3 sweep around the discharge threshold
        for (int v = VDIS - 3; v <= VDIS + 3; v++) begin
            do_reset();
            send_n(M - 1, v, 100);
            check("R3 before last sample", int'(stage), 0);
            send(v, 100);
            check("R3 exit trickle", int'(stage), (v > VDIS) ? 1 : 0);
        end
        go_bulk();
        check_outputs("R2 bulk", 1);

        // R7 restart on failing sample, hold over idle cycles
        do_reset();
        send_n(M - 1, 1200, 100);
        send(1000, 100);
        send_n(M - 1, 1200, 100);
        check("R7 restart keeps trickle", int'(stage), 0);
        send(1200, 100);
        check("R7 restart then full run", int'(stage), 1);
        do_reset();
        send_n(M - 1, 1200, 100);
        @(negedge clk);
        v_batt = VW'(900);
        repeat (5) @(negedge clk);
        check("R7 idle no step", int'(stage), 0);
        send(1200, 100);
        check("R7 idle keeps count", int'(stage), 1);

        // R4 sweep around 0.95 of overcharge voltage (knee 1425 exclusive)
        for (int v = 1422; v <= 1428; v++) begin
            go_bulk();
            send_n(M - 1, v, 100);
            check("R4 before last sample", int'(stage), 1);
            send(v, 100);
            check("R4 reach knee", int'(stage), (20 * v > 19 * VOVR) ? 2 : 1);
        end
        go_over();
        check_outputs("R2 overcharge", 2);

        // R9 conditions of other states have no effect
        go_bulk();
        send_n(N + 1, 1200, 10);
        check("R9 bulk ignores taper", int'(stage), 1);
        send_n(M + 1, 1100, 100);
        check("R9 bulk ignores sag", int'(stage), 1);
        go_over();
        send_n(M + 1, 1000, 100);
        check("R9 over ignores sag", int'(stage), 2);

        // R5 taper sweep, TAPER_N samples required
        for (int i = ITAP - 3; i <= ITAP + 3; i++) begin
            go_over();
            send_n(N - 1, 1430, i);
            check("R5 before last sample", int'(stage), 2);
            send(1430, i);
            check("R5 taper done", int'(stage), (i < ITAP) ? 3 : 2);
        end
        go_float();
        check_outputs("R2 float", 3);
        send_n(M + 1, 1430, 10);
        check("R9 float ignores knee", int'(stage), 3);

        // R6 sweep around 90% of float voltage (1215 exclusive)
        for (int v = 1212; v <= 1218; v++) begin
            go_float();
            send_n(M - 1, v, 10);
            check("R6 before last sample", int'(stage), 3);
            send(v, 10);
            check("R6 sag recharge", int'(stage), (10 * v < 9 * VFLT) ? 1 : 3);
        end

        // R8 shorted-cell fault
        do_reset();
        send_n(LIM, 1000, 100);
        check("R8 fault at limit", int'(fault_short), 0);
        repeat (4) @(negedge clk);
        check("R8 idle no count", int'(fault_short), 0);
        send(1000, 100);
        check("R8 fault above limit", int'(fault_short), 1);
        check("R8 stays trickle", int'(stage), 0);
        send_n(3, 1000, 100);
        check("R8 fault holds", int'(fault_short), 1);
        send_n(M, 1200, 100);
        check("R8 exit stage", int'(stage), 1);
        check("R8 fault clears", int'(fault_short), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule